// File: doc/BRIEF.md
# UART FIFO Interrupt Identification and Line Status Logic

This block sits beside the receive and transmit FIFOs of a 16550-class serial port, each 16 characters deep, and decides what the CPU sees when it asks why the port interrupted. It watches FIFO occupancy, the error flags of the character at the head of the receive FIFO, the transmit shift register's idle flag, the four interrupt-enable bits and the FIFO-enable bit. It also watches the CPU's strobes for reading received data, reading the identification register and writing the holding register. From these it produces a 4-bit identification code, an interrupt request line and the eight line-status bits.

Two pieces of internal timing live here. The first is a receive character timeout: it fires after four frame times with no receive activity while data waits in the FIFO. The second is a transmit-empty tracker. It holds back the "holding register empty" indication by one frame time less the stop bit, unless the transmit FIFO has held two or more characters at once since the indication last rose. Clearing all four enable bits gives a polled mode: the status bits keep working but no interrupt is raised. The shifters, the baud generator and the FIFO storage are outside this block and appear only as inputs.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous active-low reset, with both FIFOs empty and the shifter idle, iir_id is 4'h1, irq is 0 and lsr is 8'h60.
- R2: The pending source of highest priority sets iir_id. The order, from highest, is: line error 4'h6 (ier[2] and any rx_err_head bit set), received data 4'h4, character timeout 4'hC, transmitter empty 4'h2, modem 4'h0 (ier[3] and modem_irq). With nothing pending the code is 4'h1.
- R3: Received data is pending when ier[0] is 1 and the receive FIFO is non-empty. With fifo_en=1, the count must also be at least rx_trig_lvl.
- R4: With fifo_en=1, ier[0]=1 and the receive FIFO non-empty, a timeout becomes pending after 4*16*(7+word_len) tick16 pulses without a push or a read. It stays pending until one receive read, or until the FIFO becomes empty.
- R5: While no timeout is pending, rx_push and rbr_read each restart the timeout count from zero.
- R6: The transmitter-empty interrupt is set when the empty indication (lsr[5]) rises. A holding register write clears it, and so does an iir_read while iir_id reads 4'h2. It is reported when ier[1]=1.
- R7: With fifo_en=1, lsr[5] rises (16*(6+word_len)) tick16 pulses after the transmit FIFO empties, unless the FIFO held two or more characters since lsr[5] was last 1. In that case, or with fifo_en=0, it rises on the first clock edge that sees tx_count=0. Any nonzero tx_count clears lsr[5] on the next edge.
- R8: A change of fifo_en while lsr[5]=1 sets the transmitter-empty interrupt at once.
- R9: lsr bit 0 is rx_count!=0, bits 4:1 are rx_err_head, bit 5 is the empty indication, bit 6 is bit 5 and tsr_idle, and bit 7 is rx_err_any when fifo_en=1, else 0.
- R10: With ier=4'b0000 (polled mode), irq stays 0 and iir_id stays 4'h1, while lsr keeps reporting as in R9.
- R11: irq is 1 exactly when iir_id is not 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| word_len | input | 2 | Data bits minus 5 |
| fifo_en | input | 1 | FIFO mode enable |
| ier | input | 4 | Enables: 0 rx data, 1 tx empty, 2 line error, 3 modem |
| rx_count | input | 5 | Receive FIFO occupancy |
| rx_trig_lvl | input | 5 | Receive trigger threshold (1..16) |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_err_head | input | 4 | Error flags of the head receive character |
| rx_err_any | input | 1 | Some receive FIFO entry carries an error |
| tx_count | input | 5 | Transmit FIFO occupancy |
| tsr_idle | input | 1 | Transmit shift register is empty |
| modem_irq | input | 1 | Modem status change pending |
| rbr_read | input | 1 | CPU read of received data |
| iir_read | input | 1 | CPU read of the identification register |
| thr_write | input | 1 | CPU write of the holding register |
| iir_id | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |
| lsr | output | 8 | Line status bits |

## Verification
The bench counts the exact edge on which the timeout first fires, and checks that a push or read one tick short of the limit restarts it. A counter that is off by one, or one that keeps running while data is absent, shows up as a 4'hC code on the wrong cycle. The delayed-empty path is driven both with a single character and with a burst of two. A design that ignored the two-character history, or that started the delay from the wrong edge, would move the rise of lsr[5] and of code 4'h2. Clearing by IIR read is tried while a higher source masks the transmit code, so a design that cleared the flag on any read would lose an interrupt. Toggling fifo_en and running in polled mode expose a design that fails to raise the transmit interrupt, or that raises it when it should stay quiet.

// File: rtl/uart_irq_pkg.sv
// Shared codes and frame arithmetic for the UART interrupt/status logic.
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM  = 4'h0,
        IID_NONE   = 4'h1,
        IID_THRE   = 4'h2,
        IID_RXDATA = 4'h4,
        IID_LINE   = 4'h6,
        IID_TMO    = 4'hC
    } iid_e;

    // Bits in one frame: start + data (5..8) + one stop.
    function automatic int unsigned frame_bits(input logic [1:0] wl);
        return 32'd7 + 32'(wl);
    endfunction

endpackage

// File: rtl/uart_rx_timeout.sv
// Receive character timeout timer.
// Counts 16x ticks while the receive FIFO holds data and no timeout is
// pending; fires after TMO_CHARS frame times. Assumes tick16 is one cycle wide.
module uart_rx_timeout #(
    parameter int TMO_CHARS = 4,
    parameter int OVS       = 16,
    parameter int CW        = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [1:0] word_len,
    input  logic       rx_nonempty,
    input  logic       rx_push,
    input  logic       rx_read,
    output logic       fired
);
    import uart_irq_pkg::*;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = CW'(TMO_CHARS * OVS * frame_bits(word_len));

    // Advance the idle counter and latch the timeout event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (!rx_nonempty || rx_read) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (rx_push) begin
            cnt <= '0;
        end else if (!fired && tick16) begin
            if (cnt == limit - 1'b1) begin
                fired <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_thre_tracker.sv
// Transmit-empty indication with the one-frame-less-stop-bit hold-off.
// The indication rises at once if the FIFO held two or more characters
// since it was last high (or FIFOs are off); otherwise it waits.
// empty_evt pulses in the cycle whose edge raises the indication.
module uart_thre_tracker #(
    parameter int OVS = 16,
    parameter int CW  = 10,
    parameter int PW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic [1:0]    word_len,
    input  logic          fifo_en,
    input  logic [PW-1:0] tx_count,
    output logic          thre,
    output logic          empty_evt
);
    import uart_irq_pkg::*;

    logic          seen_two;
    logic [CW-1:0] dcnt;
    logic [CW-1:0] dly;
    logic          tx_empty;
    logic          fast_path;
    logic          slow_done;

    assign dly       = CW'((frame_bits(word_len) - 1) * OVS);
    assign tx_empty  = (tx_count == '0);
    assign fast_path = tx_empty && !thre && (seen_two || !fifo_en);
    assign slow_done = tx_empty && !thre && !seen_two && fifo_en
                       && tick16 && (dcnt == dly - 1'b1);
    assign empty_evt = fast_path || slow_done;

    // Track FIFO history, run the hold-off counter, update the indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre     <= 1'b1;
            seen_two <= 1'b0;
            dcnt     <= '0;
        end else if (!tx_empty) begin
            thre <= 1'b0;
            dcnt <= '0;
            if (tx_count >= PW'(2)) seen_two <= 1'b1;
        end else if (empty_evt) begin
            thre     <= 1'b1;
            seen_two <= 1'b0;
            dcnt     <= '0;
        end else if (!thre && tick16) begin
            dcnt <= dcnt + 1'b1;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder from pending sources to identification code.
// Assumes pend bits are already gated by their enables.
module uart_irq_prio (
    input  logic                    line_p,
    input  logic                    rxd_p,
    input  logic                    tmo_p,
    input  logic                    thre_p,
    input  logic                    modem_p,
    output uart_irq_pkg::iid_e      code
);
    import uart_irq_pkg::*;

    // Pick the highest-priority pending source.
    always_comb begin
        if (line_p)       code = IID_LINE;
        else if (rxd_p)   code = IID_RXDATA;
        else if (tmo_p)   code = IID_TMO;
        else if (thre_p)  code = IID_THRE;
        else if (modem_p) code = IID_MODEM;
        else              code = IID_NONE;
    end

endmodule

// File: rtl/uart_irq_status.sv
// Interrupt identification and line status for a FIFO UART.
// Combines FIFO levels, error flags and CPU strobes into the IIR code, the
// request line and the LSR bits. FIFO storage and shifters are external.
module uart_irq_status #(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    parameter int OVS       = 16,
    localparam int PW       = $clog2(DEPTH + 1),
    localparam int CW       = $clog2(TMO_CHARS * OVS * 10 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic [1:0]    word_len,
    input  logic          fifo_en,
    input  logic [3:0]    ier,
    input  logic [PW-1:0] rx_count,
    input  logic [PW-1:0] rx_trig_lvl,
    input  logic          rx_push,
    input  logic [3:0]    rx_err_head,
    input  logic          rx_err_any,
    input  logic [PW-1:0] tx_count,
    input  logic          tsr_idle,
    input  logic          modem_irq,
    input  logic          rbr_read,
    input  logic          iir_read,
    input  logic          thr_write,
    output logic [3:0]    iir_id,
    output logic          irq,
    output logic [7:0]    lsr
);
    import uart_irq_pkg::*;

    logic  tmo_fired;
    logic  thre;
    logic  empty_evt;
    logic  thr_irq;
    logic  fe_q;
    logic  rx_nonempty;
    logic  rx_avail;
    logic  line_p, rxd_p, tmo_p, thre_p, modem_p;
    iid_e  code;

    assign rx_nonempty = (rx_count != '0);
    assign rx_avail    = fifo_en ? (rx_nonempty && rx_count >= rx_trig_lvl)
                                 : rx_nonempty;

    uart_rx_timeout #(.TMO_CHARS(TMO_CHARS), .OVS(OVS), .CW(CW)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_len(word_len),
        .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_read(rbr_read),
        .fired(tmo_fired)
    );

    uart_thre_tracker #(.OVS(OVS), .CW(CW), .PW(PW)) u_thre (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_len(word_len),
        .fifo_en(fifo_en), .tx_count(tx_count),
        .thre(thre), .empty_evt(empty_evt)
    );

    assign line_p  = ier[2] && (rx_err_head != 4'b0);
    assign rxd_p   = ier[0] && rx_avail;
    assign tmo_p   = ier[0] && fifo_en && tmo_fired;
    assign thre_p  = ier[1] && thr_irq;
    assign modem_p = ier[3] && modem_irq;

    uart_irq_prio u_prio (
        .line_p(line_p), .rxd_p(rxd_p), .tmo_p(tmo_p),
        .thre_p(thre_p), .modem_p(modem_p), .code(code)
    );

    // Remember the FIFO-enable bit to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n) fe_q <= 1'b0;
        else        fe_q <= fifo_en;
    end

    // Transmitter-empty interrupt flag: set on empty or FIFO mode change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_irq <= 1'b0;
        else if (empty_evt || ((fifo_en != fe_q) && thre))
            thr_irq <= 1'b1;
        else if (thr_write || (iir_read && code == IID_THRE))
            thr_irq <= 1'b0;
    end

    assign iir_id = code;
    assign irq    = line_p | rxd_p | tmo_p | thre_p | modem_p;
    assign lsr    = {fifo_en & rx_err_any, thre & tsr_idle, thre,
                     rx_err_head, rx_nonempty};

endmodule

// File: rtl/uart_irq_status_chk.sv
// Assertion checker for uart_irq_status, attached by bind below.
module uart_irq_status_chk #(
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_en,
    input logic          fe_q,
    input logic [3:0]    ier,
    input logic [PW-1:0] rx_count,
    input logic [PW-1:0] tx_count,
    input logic          thr_write,
    input logic [3:0]    iir_id,
    input logic          irq,
    input logic [7:0]    lsr
);
    assert_polled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b0) |-> (iir_id == 4'h1 && !irq));

    assert_irq_matches_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_id != 4'h1));

    assert_temt_needs_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    assert_err_summary_fifo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> fifo_en);

    assert_no_timeout_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> (iir_id != 4'hC));

    assert_write_clears_thre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_write && tx_count != '0 && fifo_en == fe_q) |=> (iir_id != 4'h2));

    assert_thre_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0) |=> !lsr[5]);

endmodule

bind uart_irq_status uart_irq_status_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fe_q(fe_q), .ier(ier),
    .rx_count(rx_count), .tx_count(tx_count), .thr_write(thr_write),
    .iir_id(iir_id), .irq(irq), .lsr(lsr)
);

// File: tb/test_uart_irq_status.sv
`timescale 1ns/1ps
module test_uart_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] word_len = 2'd0;
    logic       fifo_en = 1'b0;
    logic [3:0] ier = 4'h0;
    logic [4:0] rx_count = 5'd0, rx_trig_lvl = 5'd1, tx_count = 5'd0;
    logic       rx_push = 0, rx_err_any = 0, tsr_idle = 1, modem_irq = 0;
    logic [3:0] rx_err_head = 4'h0;
    logic       rbr_read = 0, iir_read = 0, thr_write = 0;
    logic [3:0] iir_id;
    logic       irq;
    logic [7:0] lsr;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_status i_uart_irq_status (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_len(word_len),
        .fifo_en(fifo_en), .ier(ier), .rx_count(rx_count),
        .rx_trig_lvl(rx_trig_lvl), .rx_push(rx_push), .rx_err_head(rx_err_head),
        .rx_err_any(rx_err_any), .tx_count(tx_count), .tsr_idle(tsr_idle),
        .modem_irq(modem_irq), .rbr_read(rbr_read), .iir_read(iir_read),
        .thr_write(thr_write), .iir_id(iir_id), .irq(irq), .lsr(lsr)
    );

    // ---------------- reference model from the requirements ----------------
    int m_cnt, m_dcnt;
    bit m_fired, m_thre, m_seen2, m_tirq, m_feq;

    function automatic logic [3:0] exp_iid();
        bit avail = fifo_en ? (rx_count != 0 && rx_count >= rx_trig_lvl) : (rx_count != 0);
        if (ier[2] && rx_err_head != 0)       return 4'h6;   // R2
        if (ier[0] && avail)                   return 4'h4;   // R3
        if (ier[0] && fifo_en && m_fired)      return 4'hC;   // R4
        if (ier[1] && m_tirq)                  return 4'h2;   // R6
        if (ier[3] && modem_irq)               return 4'h0;
        return 4'h1;
    endfunction

    function automatic logic [7:0] exp_lsr();
        return {fifo_en & rx_err_any, m_thre & tsr_idle, m_thre, rx_err_head, rx_count != 0};
    endfunction

    always @(posedge clk) begin
        int lim, dly;
        bit evt;
        lim = 64 * (7 + word_len);
        dly = 16 * (6 + word_len);
        if (!rst_n) begin
            m_cnt <= 0; m_fired <= 0; m_thre <= 1; m_seen2 <= 0;
            m_dcnt <= 0; m_tirq <= 0; m_feq <= 0;
        end else begin
            // R4/R5 timeout
            if (rx_count == 0 || rbr_read) begin m_cnt <= 0; m_fired <= 0; end
            else if (rx_push) m_cnt <= 0;
            else if (!m_fired && tick16) begin
                if (m_cnt + 1 == lim) begin m_fired <= 1; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
            // R7 empty indication
            evt = 0;
            if (tx_count != 0) begin
                m_thre <= 0; m_dcnt <= 0;
                if (tx_count >= 2) m_seen2 <= 1;
            end else if (!m_thre) begin
                if (m_seen2 || !fifo_en) evt = 1;
                else if (tick16) begin
                    if (m_dcnt + 1 == dly) evt = 1;
                    else m_dcnt <= m_dcnt + 1;
                end
                if (evt) begin m_thre <= 1; m_seen2 <= 0; m_dcnt <= 0; end
            end
            // R6/R8 interrupt flag
            if (evt || (fifo_en != m_feq && m_thre)) m_tirq <= 1;
            else if (thr_write || (iir_read && exp_iid() == 4'h2)) m_tirq <= 0;
            m_feq <= fifo_en;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: wait for the falling edge and compare outputs against the model.
    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_n) begin
                check(iir_id == exp_iid(), "R2 iir_id", iir_id, exp_iid());
                check(irq == (exp_iid() != 4'h1), "R11 irq", irq, exp_iid() != 4'h1);
                check(lsr == exp_lsr(), "R9 lsr", lsr, exp_lsr());
            end
        end
    endtask

    task automatic clr_strobes();
        rx_push = 0; rbr_read = 0; iir_read = 0; thr_write = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(iir_id == 4'h1 && !irq, "R1 iir/irq", {irq, iir_id}, 4'h1);
        check(lsr == 8'h60, "R1 lsr", lsr, 8'h60);
        rst_n = 1;
        step(2);

        // R4/R5: timeout, exact firing edge, restart by push
        fifo_en = 1; ier = 4'h1; rx_trig_lvl = 5'd8; tick16 = 1; word_len = 0;
        step(2);                                   // let fifo_en change settle
        rx_count = 1; rx_push = 1; step(1); rx_push = 0;
        step(446);
        check(iir_id == 4'h1, "R5 before limit", iir_id, 4'h1);
        rx_count = 2; rx_push = 1; step(1); rx_push = 0;  // restart
        step(447);
        check(iir_id == 4'h1, "R5 restarted by push", iir_id, 4'h1);
        step(1);
        check(iir_id == 4'hC && irq, "R4 timeout fires", iir_id, 4'hC);
        rx_push = 1; step(3); rx_push = 0;
        check(iir_id == 4'hC, "R4 push keeps timeout", iir_id, 4'hC);
        rbr_read = 1; rx_count = 1; step(1); rbr_read = 0; step(1);
        check(iir_id == 4'h1, "R4 read clears timeout", iir_id, 4'h1);
        rx_count = 8; step(1);
        check(iir_id == 4'h4, "R3 trigger reached", iir_id, 4'h4);
        fifo_en = 0; rx_count = 1; step(1);
        check(iir_id == 4'h4, "R3 non-FIFO any byte", iir_id, 4'h4);
        rx_count = 0; fifo_en = 1; step(2);

        // R7: single-character hold-off
        ier = 4'h2; iir_read = 1; step(1); iir_read = 0; step(1);  // clear flag
        tx_count = 1; thr_write = 1; step(1); thr_write = 0; step(3);
        check(!lsr[5], "R7 not empty", lsr[5], 0);
        tx_count = 0; step(95);
        check(!lsr[5] && iir_id == 4'h1, "R7 held off", {lsr[5], iir_id}, 4'h1);
        step(1);
        check(lsr[5] && iir_id == 4'h2, "R7 delayed rise", {lsr[5], iir_id}, 5'h12);
        // R6: cleared by IIR read reporting 02
        iir_read = 1; step(1); iir_read = 0; step(1);
        check(iir_id == 4'h1, "R6 IIR read clears", iir_id, 4'h1);
        // R7: two characters -> immediate
        tx_count = 2; thr_write = 1; step(1); thr_write = 0; tx_count = 1; step(2);
        tx_count = 0; step(1);
        check(lsr[5] && iir_id == 4'h2, "R7 immediate after two", {lsr[5], iir_id}, 5'h12);
        // R6: IIR read while masked by higher source does not clear
        ier = 4'h6; rx_err_head = 4'h2; iir_read = 1; step(1); iir_read = 0;
        rx_err_head = 0; step(1);
        check(iir_id == 4'h2, "R6 masked read keeps", iir_id, 4'h2);
        tx_count = 1; thr_write = 1; step(1); thr_write = 0; tx_count = 0; step(1);
        check(iir_id == 4'h1, "R6 write clears", iir_id, 4'h1);
        step(120);
        iir_read = 1; step(1); iir_read = 0;
        // R8: FIFO mode change raises transmitter interrupt
        fifo_en = 0; step(1);
        check(iir_id == 4'h2, "R8 fifo_en change", iir_id, 4'h2);
        // R10: polled mode
        fifo_en = 1; ier = 0; rx_count = 3; rx_err_head = 4'h8; rx_err_any = 1; step(2);
        check(iir_id == 4'h1 && !irq, "R10 polled quiet", iir_id, 4'h1);
        check(lsr[0] && lsr[4] && lsr[7], "R10 polled lsr", lsr, exp_lsr());
        rx_err_head = 0; rx_err_any = 0; rx_count = 0; step(1);

        // Random phase
        for (int seg = 0; seg < 6; seg++) begin
            word_len = 2'($urandom);
            rx_trig_lvl = 5'($urandom_range(1, 16));
            for (int c = 0; c < 1500; c++) begin
                clr_strobes();
                tick16 = ($urandom % 3) != 0;
                if ($urandom % 200 == 0) fifo_en = ~fifo_en;
                if ($urandom % 100 == 0) ier = 4'($urandom);
                if ($urandom % 6 == 0 && rx_count < 16) begin rx_count++; rx_push = 1; end
                else if ($urandom % (seg < 3 ? 8 : 400) == 0 && rx_count > 0) begin
                    rx_count--; rbr_read = 1;
                end
                if ($urandom % 9 == 0 && tx_count < 16) begin
                    tx_count = tx_count + 5'($urandom_range(1, 2));
                    if (tx_count > 16) tx_count = 16;
                    thr_write = 1;
                end else if ($urandom % 5 == 0 && tx_count > 0) tx_count--;
                rx_err_head = ($urandom % 20 == 0) ? 4'($urandom) : 4'h0;
                rx_err_any = ($urandom % 10 == 0);
                tsr_idle = ($urandom % 4) != 0;
                modem_irq = ($urandom % 30 == 0);
                iir_read = ($urandom % 10 == 0);
                step(1);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule